// File: doc/BRIEF.md
# Global Shutter Exposure Timer

This block times the exposure window of an image sensor running a synchronous (global) shutter. A single-cycle start strobe loads an exposure length and a tick size, then arms a line counter. The counter advances once per tick. A tick is a programmable power-of-two number of system clocks, from 1 up to 256. When the counter reaches the loaded exposure length, the block raises a time-out strobe for exactly one clock. The surrounding logic uses that strobe to end the integration.

The exposure length is a 12-bit value. The shortest legal length is 10 ticks, and a smaller request is raised to 10 when it is loaded. The block reads the exposure length and the tick code only on the start strobe, so both may change freely during an exposure. A new start strobe in the middle of an exposure discards the run in progress and begins timing again from zero. With a 40 MHz system clock, the full-scale value and the largest tick give roughly 26.2 ms of exposure.

Top module: `gs_expo_timer`

## Requirements
- R1: After reset, `busy_o` and `timeout_o` are both 0.
- R2: A cycle with `start_i` = 1 makes `busy_o` read 1 at the next clock edge.
- R3: With effective exposure length T and tick size P, `timeout_o` is 1 exactly T*P clock edges after the edge that sampled `start_i`. It lasts one cycle, and `busy_o` drops at that same edge.
- R4: Tick code c on `gran_sel_i` gives P = 2^c system clocks for c = 0..8. Codes 9..15 give P = 256.
- R5: An `int_val_i` below 10 is loaded as 10. Any other value is loaded unchanged.
- R6: A start strobe while `busy_o` = 1 restarts the timing from zero, using the newly sampled length and code. No time-out appears for the abandoned run.
- R7: Changes to `int_val_i` and `gran_sel_i` while `busy_o` = 1 have no effect on the time-out cycle.
- R8: `timeout_o` is never 1 while `busy_o` = 1, and it never stays high for two cycles in a row.
- R9: Without a start strobe, an idle block keeps `busy_o` and `timeout_o` at 0 whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Shutter start strobe, one cycle |
| int_val_i | input | 12 | Exposure length in ticks, sampled on start |
| gran_sel_i | input | 4 | Tick size code, sampled on start |
| timeout_o | output | 1 | One-cycle end-of-exposure strobe |
| busy_o | output | 1 | High while an exposure is being timed |

## Verification
The assertions assume that `start_i` is a clean synchronous level and that reset is held for at least one edge. They also assume the time-out and a start strobe can meet only when a start lands on the final tick, in which case the start takes precedence. The stimulus drives every input at the falling edge. It limits random exposure lengths by tick code so that T*P stays small enough for the cycle budget. The directed cases still reach the full-scale length at unit ticks and the 256-clock tick through both a legal code and an out-of-range code.

// File: rtl/gs_expo_timer.sv
module gs_expo_timer #(
  parameter int CNT_W     = 12,
  parameter int GSEL_W    = 4,
  parameter int MAX_SHIFT = 8,
  parameter int MIN_VAL   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  int_val_i,
  input  logic [GSEL_W-1:0] gran_sel_i,
  output logic              timeout_o,
  output logic              busy_o
);
  localparam int PRE_W = MAX_SHIFT;

  logic [CNT_W-1:0]  cnt_q, tgt_q, cnt_nxt, tgt_new;
  logic [PRE_W-1:0]  pre_q, mask_q, mask_new;
  logic [GSEL_W-1:0] shift_eff;
  logic              busy_q, to_q, tick, last;

  assign shift_eff = (gran_sel_i > GSEL_W'(MAX_SHIFT)) ? GSEL_W'(MAX_SHIFT) : gran_sel_i;
  assign tgt_new   = (int_val_i < CNT_W'(MIN_VAL)) ? CNT_W'(MIN_VAL) : int_val_i;

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask_new[i] = (GSEL_W'(i) < shift_eff);
  end

  assign tick    = busy_q && ((pre_q & mask_q) == mask_q);
  assign cnt_nxt = cnt_q + CNT_W'(1);
  assign last    = tick && (cnt_nxt == tgt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      to_q   <= 1'b0;
      cnt_q  <= '0;
      tgt_q  <= '0;
      pre_q  <= '0;
      mask_q <= '0;
    end else begin
      to_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        pre_q  <= '0;
        tgt_q  <= tgt_new;
        mask_q <= mask_new;
      end else if (busy_q) begin
        pre_q <= pre_q + PRE_W'(1);
        if (last) begin
          busy_q <= 1'b0;
          to_q   <= 1'b1;
        end else if (tick) begin
          cnt_q <= cnt_nxt;
        end
      end
    end
  end

  assign timeout_o = to_q;
  assign busy_o    = busy_q;

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);                                               // R2
  AST_TO_END_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> ($past(busy_o) && !$past(start_i) && !busy_o));      // R3
  AST_CNT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt_q < tgt_q));                                       // R3
  AST_TGT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (tgt_q >= CNT_W'(MIN_VAL)));                            // R5
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);                                         // R8
  AST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !busy_o);                                            // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> (!timeout_o && !busy_o));                // R9
endmodule

// File: tb/gs_expo_timer_tb.sv
module gs_expo_timer_tb;
  logic        clk = 0, rst_n = 0, start_i = 0;
  logic [11:0] int_val_i = 0;
  logic [3:0]  gran_sel_i = 0;
  logic        timeout_o, busy_o;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  gs_expo_timer u_dut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .int_val_i(int_val_i),
                       .gran_sel_i(gran_sel_i), .timeout_o(timeout_o), .busy_o(busy_o));

  function automatic int exp_cycles(int v, int c);
    int t = (v < 10) ? 10 : v;
    int p = (c > 8) ? 256 : (1 << c);
    return t * p;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start(int v, int c);
    @(negedge clk);
    start_i = 1; int_val_i = 12'(v); gran_sel_i = 4'(c);
    @(negedge clk);
    start_i = 0;
  endtask

  // after pulse_start we sit at the negedge following the start edge (k=0)
  task automatic run_case(int v, int c, bit scramble, string tag);
    int k = 0, exp = exp_cycles(v, c);
    bit early = 0;
    pulse_start(v, c);
    check(busy_o === 1'b1, "R2 busy after start", int'(busy_o), 1);
    if (scramble) begin
      int_val_i = 12'($urandom); gran_sel_i = 4'($urandom);
    end
    while (k < exp + 5) begin
      @(negedge clk); k++;
      if (timeout_o === 1'b1) break;
      if (busy_o !== 1'b1 && !early) begin early = 1; end
    end
    check(k == exp && !early, tag, k, exp);
    check(busy_o === 1'b0, "R3 busy low with timeout", int'(busy_o), 0);
    @(negedge clk);
    check(timeout_o === 1'b0, "R8 single-cycle timeout", int'(timeout_o), 0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy_o === 1'b0 && timeout_o === 1'b0, "R1 reset state",
          int'({busy_o, timeout_o}), 0);

    // R9 idle with noisy inputs
    begin
      bit seen = 0;
      for (int i = 0; i < 40; i++) begin
        int_val_i = 12'($urandom); gran_sel_i = 4'($urandom);
        @(negedge clk);
        if (busy_o !== 1'b0 || timeout_o !== 1'b0) seen = 1;
      end
      check(!seen, "R9 idle stays quiet", int'(seen), 0);
    end

    run_case(3, 0, 0, "R5 clamp small value");
    run_case(0, 1, 0, "R5 clamp zero value");
    run_case(10, 0, 0, "R3 minimum legal value");
    run_case(10, 8, 0, "R4 code 8 gives 256");
    run_case(12, 15, 0, "R4 code 15 gives 256");
    run_case(11, 9, 0, "R4 code 9 gives 256");
    run_case(4095, 0, 0, "R3 full scale unit tick");
    run_case(37, 3, 1, "R7 inputs ignored while busy");

    // R6 restart mid-run
    begin
      int k = 0;
      bit bad = 0;
      pulse_start(20, 0);
      repeat (6) @(negedge clk);
      pulse_start(12, 1);
      while (k < 40) begin
        @(negedge clk); k++;
        if (timeout_o === 1'b1) break;
      end
      check(k == 24, "R6 restart from zero", k, 24);
      repeat (30) begin
        @(negedge clk);
        if (timeout_o === 1'b1) bad = 1;
      end
      check(!bad, "R6 no stale timeout", int'(bad), 0);
    end

    for (int i = 0; i < 10; i++) begin
      int c = int'($urandom % 16);
      int v = (c < 5) ? int'($urandom % 400) : int'($urandom % 32);
      run_case(v, c, i[0], "R3 R4 random case");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule